// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Process Tags

The block caches recent page translations. Each of its entries pairs a virtual page number with a physical frame number. Each entry also carries the identifier of the address space that owns it, a flag that pins it in place, and a bit that says whether the page is present. A lookup presents a page number, an address-space identifier and a page offset. In the same cycle the block compares them against every entry and answers with a hit, a miss or a trap. On a hit it also returns the physical address, which is the stored frame number followed by the unchanged offset.

Software or a page-table walker loads entries through a fill port after a miss. A fill goes into the lowest-numbered empty entry. When the cache is full, a round-robin pointer picks the entry to replace and never picks a pinned entry. A fill whose key is already cached updates that entry in place. A flush port removes every unpinned entry, or only the unpinned entries of one address space. Fills and flushes take effect at the next clock edge. When both arrive in the same cycle, the flush is applied first.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup whose page number and identifier both match an occupied entry marked present asserts `lk_hit`. It drives `lk_paddr` as {stored frame, `lk_offset`}, with the frame in the upper PFN_W bits and the offset in the lower 12 bits.
- R2: A lookup that matches no occupied entry drives `lk_hit`=0, `lk_trap`=0 and `lk_paddr`=0.
- R3: An entry whose page number matches but whose identifier differs from `lk_asid` is not a match, so the lookup misses.
- R4: A lookup that matches an entry filled with `fill_present`=0 asserts `lk_trap`, keeps `lk_hit` at 0 and drives `lk_paddr`=0. `lk_hit` and `lk_trap` are never both 1.
- R5: A fill whose key matches no entry writes the lowest-indexed empty entry, if there is one.
- R6: When no entry is empty, a fill replaces the first unpinned entry found by scanning upward, with wrap-around, from a round-robin pointer. The pointer is 0 after reset and moves to the index after the replaced entry. Only replacements move the pointer.
- R7: A fill whose page number and identifier match an occupied entry overwrites that entry in place, including its pinned and present bits. No two entries ever match the same lookup.
- R8: A fill that needs a victim when every entry is pinned is dropped, and `fill_err` pulses high for one cycle in the cycle after the fill.
- R9: `flush_all` removes every unpinned entry at the next clock edge.
- R10: `flush_one` removes at the next clock edge only the unpinned entries whose identifier equals `flush_asid`.
- R11: A pinned entry is never removed by a flush or by a replacement.
- R12: When a fill and a flush arrive in the same cycle, the flush is applied first, and the fill then sees the flushed contents.
- R13: After reset every entry is empty, so every lookup misses, and `fill_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_offset | input | 12 | Page offset passed through to the physical address |
| lk_hit | output | 1 | Lookup matched a present entry |
| lk_trap | output | 1 | Lookup matched an entry whose page is not present |
| lk_paddr | output | 32 | Physical address on a hit, zero otherwise |
| fill_en | input | 1 | Write an entry at the next edge |
| fill_vpn | input | 20 | Page number to write |
| fill_asid | input | 8 | Identifier to write |
| fill_pfn | input | 20 | Frame number to write |
| fill_pinned | input | 1 | Entry may not be replaced or flushed |
| fill_present | input | 1 | Page is present; 0 makes lookups trap |
| flush_all | input | 1 | Remove all unpinned entries |
| flush_one | input | 1 | Remove unpinned entries of `flush_asid` |
| flush_asid | input | 8 | Identifier for `flush_one` |
| fill_err | output | 1 | One-cycle pulse: the previous fill was dropped |

## Verification
The assertions check the following on every cycle: hit and trap are mutually exclusive, no lookup ever matches two entries, a pinned entry stays occupied from one cycle to the next, a replacement victim is never pinned, the error pulse follows a fill, and the offset appears unchanged in the physical address on a hit. Other behaviours can be shown only by the bench's scenarios against its reference array. These are the placement order into empty entries, the round-robin victim sequence, identifier isolation, the two flush scopes, flush-before-fill ordering, and the dropped fill when every entry is pinned.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef struct packed {
        logic used;
        logic pinned;
        logic present;
    } ent_flags_t;

    typedef enum logic [2:0] {
        FA_NONE,
        FA_OVERWRITE,
        FA_EMPTY,
        FA_EVICT,
        FA_DROP
    } fill_act_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int unsigned N      = 16,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned ASID_W = 8
) (
    input  logic [N-1:0]             used,
    input  logic [N-1:0][VPN_W-1:0]  vpn,
    input  logic [N-1:0][ASID_W-1:0] asid,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [N-1:0]             match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = used[i] && (vpn[i] == key_vpn) && (asid[i] == key_asid);
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int unsigned N     = 16,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     free_vec,
    input  logic [N-1:0]     cand_vec,
    input  logic [IDX_W-1:0] rr,
    output logic             has_free,
    output logic [IDX_W-1:0] free_idx,
    output logic             has_cand,
    output logic [IDX_W-1:0] cand_idx
);
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        has_cand = 1'b0;
        cand_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (cand_vec[(int'(rr) + k) % N]) begin
                has_cand = 1'b1;
                cand_idx = IDX_W'((int'(rr) + k) % N);
            end
        end
    end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int unsigned N      = 16,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PFN_W  = 20,
    parameter int unsigned ASID_W = 8,
    parameter int unsigned OFF_W  = 12,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned PA_W  = PFN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [OFF_W-1:0]  lk_offset,
    output logic              lk_hit,
    output logic              lk_trap,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_pinned,
    input  logic              fill_present,
    input  logic              flush_all,
    input  logic              flush_one,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              fill_err
);
    typedef struct packed {
        ent_flags_t [N-1:0]             flg;
        logic [N-1:0][VPN_W-1:0]        vpn;
        logic [N-1:0][ASID_W-1:0]       asid;
        logic [N-1:0][PFN_W-1:0]        pfn;
        logic [IDX_W-1:0]               rr;
        logic                           err;
    } state_t;

    state_t state_q, state_d;

    logic [N-1:0] used_q, pinned_q, present_q;
    logic [N-1:0] used_post;
    logic [N-1:0] lk_match, dup_match;
    logic         has_free, has_cand;
    logic [IDX_W-1:0] free_idx, cand_idx, dup_idx, wr_idx;
    fill_act_e    fill_act;
    logic [PFN_W-1:0] sel_pfn;
    logic         sel_present;

    for (genvar i = 0; i < N; i++) begin : g_flags
        assign used_q[i]    = state_q.flg[i].used;
        assign pinned_q[i]  = state_q.flg[i].pinned;
        assign present_q[i] = state_q.flg[i].present;
    end

    // ---------------- lookup path (combinational)
    tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
        .used(used_q), .vpn(state_q.vpn), .asid(state_q.asid),
        .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match)
    );

    always_comb begin
        sel_pfn     = '0;
        sel_present = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) begin
                sel_pfn     = sel_pfn | state_q.pfn[i];
                sel_present = sel_present | present_q[i];
            end
        end
        lk_hit   = (|lk_match) && sel_present;
        lk_trap  = (|lk_match) && !sel_present;
        lk_paddr = lk_hit ? {sel_pfn, lk_offset} : '0;
    end

    // ---------------- flush stage (applied before fill)
    always_comb begin
        for (int i = 0; i < N; i++) begin
            used_post[i] = used_q[i] &&
                !(!pinned_q[i] && (flush_all || (flush_one && state_q.asid[i] == flush_asid)));
        end
    end

    tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cam (
        .used(used_post), .vpn(state_q.vpn), .asid(state_q.asid),
        .key_vpn(fill_vpn), .key_asid(fill_asid), .match(dup_match)
    );

    tlb_pick #(.N(N)) u_pick (
        .free_vec(~used_post), .cand_vec(used_post & ~pinned_q), .rr(state_q.rr),
        .has_free(has_free), .free_idx(free_idx),
        .has_cand(has_cand), .cand_idx(cand_idx)
    );

    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (dup_match[i]) dup_idx = IDX_W'(i);
        end
    end

    // ---------------- fill decision
    always_comb begin
        fill_act = FA_NONE;
        wr_idx   = '0;
        if (fill_en) begin
            if (|dup_match) begin
                fill_act = FA_OVERWRITE;
                wr_idx   = dup_idx;
            end else if (has_free) begin
                fill_act = FA_EMPTY;
                wr_idx   = free_idx;
            end else if (has_cand) begin
                fill_act = FA_EVICT;
                wr_idx   = cand_idx;
            end else begin
                fill_act = FA_DROP;
            end
        end
    end

    // ---------------- next state
    always_comb begin
        state_d     = state_q;
        state_d.err = (fill_act == FA_DROP);
        for (int i = 0; i < N; i++) begin
            state_d.flg[i].used = used_post[i];
        end
        if (fill_act == FA_OVERWRITE || fill_act == FA_EMPTY || fill_act == FA_EVICT) begin
            state_d.flg[wr_idx]  = '{used: 1'b1, pinned: fill_pinned, present: fill_present};
            state_d.vpn[wr_idx]  = fill_vpn;
            state_d.asid[wr_idx] = fill_asid;
            state_d.pfn[wr_idx]  = fill_pfn;
        end
        if (fill_act == FA_EVICT) begin
            state_d.rr = (int'(wr_idx) == N - 1) ? '0 : wr_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fill_err = state_q.err;

    // ---------------- assertions
    assert_hit_trap_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_trap)) else $error("hit and trap together");

    assert_unique_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)) else $error("duplicate entries match one lookup");

    assert_offset_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_offset)) else $error("offset altered");

    assert_victim_unpinned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_act == FA_EVICT) |-> !pinned_q[wr_idx]) else $error("pinned victim");

    assert_err_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> $past(fill_en)) else $error("error pulse without fill");

    for (genvar i = 0; i < N; i++) begin : g_pin_chk
        assert_pinned_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (used_q[i] && pinned_q[i]) |=> used_q[i]) else $error("pinned entry lost");
    end

endmodule

// File: tb/sim_tlb_assoc.sv
module sim_tlb_assoc;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic [11:0] lk_offset = '0;
    logic        lk_hit, lk_trap, fill_err;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_pinned = 1'b0, fill_present = 1'b0;
    logic        flush_all = 1'b0, flush_one = 1'b0;
    logic [7:0]  flush_asid = '0;

    always #5 clk = ~clk;

    tlb_assoc u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_offset(lk_offset),
        .lk_hit(lk_hit), .lk_trap(lk_trap), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_pinned(fill_pinned), .fill_present(fill_present),
        .flush_all(flush_all), .flush_one(flush_one), .flush_asid(flush_asid),
        .fill_err(fill_err)
    );

    // reference model
    bit m_used[N], m_pin[N], m_pres[N];
    int m_vpn[N], m_asid[N], m_pfn[N];
    int m_rr;
    bit exp_err;
    int n_chk = 0, n_fail = 0;

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_used[i] = 0; m_pin[i] = 0; m_pres[i] = 0;
            m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0;
        end
        m_rr = 0; exp_err = 0;
    endtask

    task automatic model_update();
        int dup, emp, vic;
        if (flush_all || flush_one)
            for (int i = 0; i < N; i++)
                if (m_used[i] && !m_pin[i] && (flush_all || m_asid[i] == int'(flush_asid)))
                    m_used[i] = 0;
        exp_err = 0;
        if (!fill_en) return;
        dup = -1; emp = -1; vic = -1;
        for (int i = 0; i < N; i++)
            if (m_used[i] && m_vpn[i] == int'(fill_vpn) && m_asid[i] == int'(fill_asid)) dup = i;
        for (int i = N - 1; i >= 0; i--) if (!m_used[i]) emp = i;
        for (int k = N - 1; k >= 0; k--) if (!m_pin[(m_rr + k) % N]) vic = (m_rr + k) % N;
        if (dup < 0 && emp < 0 && vic < 0) begin
            exp_err = 1;
            return;
        end
        if (dup >= 0) vic = dup;
        else if (emp >= 0) vic = emp;
        else m_rr = (vic + 1) % N;
        m_used[vic] = 1; m_pin[vic] = fill_pinned; m_pres[vic] = fill_present;
        m_vpn[vic] = int'(fill_vpn); m_asid[vic] = int'(fill_asid); m_pfn[vic] = int'(fill_pfn);
    endtask

    // one cycle: inputs already set; compare outputs then advance model at the edge
    task automatic step(string req);
        bit h, t;
        longint pa;
        h = 0; t = 0; pa = 0;
        #1;
        for (int i = 0; i < N; i++)
            if (m_used[i] && m_vpn[i] == int'(lk_vpn) && m_asid[i] == int'(lk_asid)) begin
                h = m_pres[i]; t = !m_pres[i];
                if (m_pres[i]) pa = (longint'(m_pfn[i]) << 12) | longint'(lk_offset);
            end
        check(req, "lk_hit", lk_hit, h);
        check(req, "lk_trap", lk_trap, t);
        check(req, "lk_paddr", lk_paddr, pa);
        check(req, "fill_err", fill_err, exp_err);
        @(posedge clk);
        model_update();
        @(negedge clk);
        fill_en = 0; flush_all = 0; flush_one = 0;
    endtask

    task automatic look(int v, int a, string req);
        lk_vpn = 20'(v); lk_asid = 8'(a); lk_offset = 12'($urandom);
        step(req);
    endtask

    task automatic fill(int v, int a, int p, bit pin, bit pres, string req);
        fill_en = 1; fill_vpn = 20'(v); fill_asid = 8'(a); fill_pfn = 20'(p);
        fill_pinned = pin; fill_present = pres;
        step(req);
    endtask

    task automatic flush(bit all, int a, string req);
        flush_all = all; flush_one = !all; flush_asid = 8'(a);
        step(req);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13: empty after reset
        look(0, 0, "R13"); look(5, 1, "R13");
        // R1 / R2 / R3
        fill('h12345, 3, 'hABCDE, 0, 1, "R5");
        look('h12345, 3, "R1");
        look('h12346, 3, "R2");
        look('h12345, 4, "R3");
        // R4 trap on non-present page
        fill('h00777, 3, 'h11111, 0, 0, "R4");
        look('h00777, 3, "R4");
        // R7 overwrite in place
        fill('h12345, 3, 'h55555, 0, 1, "R7");
        look('h12345, 3, "R7");
        // R10 per-identifier flush
        fill('h00200, 1, 'h00001, 0, 1, "R10");
        fill('h00200, 2, 'h00002, 0, 1, "R10");
        flush(0, 1, "R10");
        look('h00200, 1, "R10"); look('h00200, 2, "R10");
        // R9 global flush
        flush(1, 0, "R9");
        look('h00200, 2, "R9"); look('h12345, 3, "R9");
        // R12 flush and fill in the same cycle
        flush_all = 1; fill('h00333, 7, 'h00333, 0, 1, "R12");
        look('h00333, 7, "R12");
        // R5/R6 fill to full then round-robin replacement
        flush(1, 0, "R6");
        for (int i = 0; i < 40; i++) begin
            fill('h1000 + i, 5, 'h2000 + i, 0, 1, "R6");
            look('h1000 + i - 16, 5, "R6");
            look('h1000 + i - 17, 5, "R6");
        end
        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom_range(0, 99);
            lk_vpn = 20'($urandom_range(0, 31)); lk_asid = 8'($urandom_range(0, 3));
            lk_offset = 12'($urandom);
            if (op < 55) begin
                fill_en = 1; fill_vpn = 20'($urandom_range(0, 31));
                fill_asid = 8'($urandom_range(0, 3)); fill_pfn = 20'($urandom);
                fill_pinned = ($urandom_range(0, 49) == 0); fill_present = ($urandom_range(0, 4) != 0);
            end
            if (op >= 95) flush_all = 1;
            else if (op >= 90) begin flush_one = 1; flush_asid = 8'($urandom_range(0, 3)); end
            step("R1 R2 R3 R4 R5 R6 R7 R9 R10 R12");
        end
        // R11 pinned entries survive flush and replacement pressure
        flush(1, 0, "R11");
        for (int i = 0; i < N; i++) fill('h9000 + i, 9, 'h100 + i, 0, 1, "R11");
        fill('h9000, 9, 'h300, 1, 1, "R11");
        fill('h9005, 9, 'h305, 1, 1, "R11");
        for (int i = 0; i < 40; i++) fill('hA000 + i, 9, i, 0, 1, "R11");
        flush(1, 0, "R11"); flush(0, 9, "R11");
        look('h9000, 9, "R11"); look('h9005, 9, "R11");
        // R8 every entry pinned: fill dropped, error pulse
        for (int i = 0; i < N; i++) fill('hB000 + i, 2, i, 1, 1, "R8");
        fill('hC000, 2, 'h1, 0, 1, "R8");
        look('hC000, 2, "R8");
        look('hB003, 2, "R8");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule